// File: doc/BRIEF.md
# Branch Target Buffer with Direction Counters

This block sits beside the instruction fetch stage and remembers where taken branches went. It is organised as a set-associative store. Each entry holds the branch address as a tag, the branch destination, and a 2-bit saturating direction counter. Every cycle the fetch PC is compared against all ways of one set. When an entry matches and its counter leans taken, the block reports the stored destination so that the next fetch can be steered there. In every other case fetch continues sequentially.

Entries change only after a branch has resolved, through a separate update port. A resolved branch that is already present adjusts its counter. It also refreshes its destination when the branch was taken. A resolved branch that is absent gets an entry only when it was taken. It fills an empty way first and otherwise replaces the way that a tree pseudo-LRU picks. Each accepted update keeps the update port busy for one extra cycle, during which the write takes place.

Top module: `tgt_predict_buf`

## Requirements
- R1: After a synchronous reset every way is empty, so every lookup reports hit=0, taken=0 and target=0, and up_ready is 1.
- R2: Lookup results are registered. The result for the PC presented before a rising edge appears after that edge and stays unchanged until the next edge.
- R3: A resolved not-taken branch with no matching entry creates no entry.
- R4: A resolved taken branch with no matching entry is installed with counter value 2'b10 (weakly taken), so a later lookup of it reports hit=1, taken=1 and its destination.
- R5: The counter is 2 bits wide and saturates at 0 and 3. A taken resolution increments it and a not-taken resolution decrements it. A hit predicts taken exactly when bit 1 of the counter is set. On a hit that predicts not taken, the block reports hit=1, taken=0 and target=0.
- R6: A taken resolution on a matching entry overwrites the stored destination with the resolved one. A not-taken resolution leaves the stored destination unchanged.
- R7: In the cycle after an update is accepted (up_valid with up_ready high), up_ready is 0. An update offered while up_ready is 0 is ignored and has no effect.
- R8: With the default parameters, the set is selected by PC bits [5:2] and the tag is PC bits [31:6]. PC bits [1:0] take no part in matching.
- R9: A set holds up to four distinct branches at once. Empty ways are filled before any way is replaced.
- R10: In a full set, the victim is chosen by a 3-bit tree pseudo-LRU that every update touches. After installs A, B, C, D in that order, a hit update on A, and then a new taken branch E, entry C is evicted while A, B, D and E remain.
- R11: A lookup sampled at the same edge that writes an update into the buffer sees the contents from before that write. The following lookup sees the new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Fetch address to look up |
| lk_hit | output | 1 | Registered: the looked-up address matched an entry |
| lk_taken | output | 1 | Registered: redirect fetch (hit and counter bit 1 set) |
| lk_target | output | PC_W | Registered: predicted destination, zero unless lk_taken |
| up_valid | input | 1 | A resolved branch is offered |
| up_ready | output | 1 | Update port can accept this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction, 1 = taken |
| up_target | input | PC_W | Resolved destination |

## Verification
A lookup result is due one edge after the PC is applied. The bench therefore applies each PC at a falling edge and compares the outputs at the next falling edge, and the R2 check also looks between edges to confirm that the output has held. An update is accepted at one edge and written at the next. The bench samples up_ready at the falling edge between those two edges, and it starts every lookup that depends on an update only after the write edge, except in the R11 case, where the lookup is deliberately aligned with the write edge. Expected counters, destinations and evictions come from arithmetic kept in the bench, not from the design.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_TAKEN = 2'b10;

  // saturating two-bit direction counter step
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == 2'b11) ? cur : cur + 2'd1;
    else       nxt = (cur == 2'b00) ? cur : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/tpb_way.sv
// One way of the buffer: tag, destination and counter storage plus valid bits.
// Two read ports (lookup, update) and one write port.
module tpb_way #(
  parameter int SETS  = 16,
  parameter int TAG_W = 26,
  parameter int PC_W  = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IDX_W-1:0]     ra_idx,
  output logic                 ra_valid,
  output logic [TAG_W-1:0]     ra_tag,
  output logic [PC_W-1:0]      ra_tgt,
  output tpb_pkg::ctr_t        ra_ctr,
  input  logic [IDX_W-1:0]     rb_idx,
  output logic                 rb_valid,
  output logic [TAG_W-1:0]     rb_tag,
  output logic [PC_W-1:0]      rb_tgt,
  output tpb_pkg::ctr_t        rb_ctr,
  input  logic                 we,
  input  logic [IDX_W-1:0]     w_idx,
  input  logic [TAG_W-1:0]     w_tag,
  input  logic [PC_W-1:0]      w_tgt,
  input  tpb_pkg::ctr_t        w_ctr
);

  logic [TAG_W-1:0]    tag_mem [SETS];
  logic [PC_W-1:0]     tgt_mem [SETS];
  tpb_pkg::ctr_t       ctr_mem [SETS];
  logic [SETS-1:0]     valid_q;

  // storage arrays carry no reset so they can map onto RAM
  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[w_idx] <= w_tag;
      tgt_mem[w_idx] <= w_tgt;
      ctr_mem[w_idx] <= w_ctr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     valid_q <= '0;
    else if (we) valid_q[w_idx] <= 1'b1;
  end

  assign ra_valid = valid_q[ra_idx];
  assign ra_tag   = tag_mem[ra_idx];
  assign ra_tgt   = tgt_mem[ra_idx];
  assign ra_ctr   = ctr_mem[ra_idx];

  assign rb_valid = valid_q[rb_idx];
  assign rb_tag   = tag_mem[rb_idx];
  assign rb_tgt   = tgt_mem[rb_idx];
  assign rb_ctr   = ctr_mem[rb_idx];

endmodule

// File: rtl/tpb_plru.sv
// Tree pseudo-LRU state per set. Heap-numbered nodes 1..WAYS-1; each bit
// points toward the less recently used half.
module tpb_plru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WAY_W-1:0]  victim,
  input  logic              touch,
  input  logic [IDX_W-1:0]  t_idx,
  input  logic [WAY_W-1:0]  t_way
);

  logic [WAYS-1:0] tree_q [SETS];
  logic [WAYS-1:0] cur_tree;
  logic [WAYS-1:0] nxt_tree;

  always_comb begin
    int node;
    cur_tree = tree_q[rd_idx];
    node = 1;
    for (int l = 0; l < WAY_W; l++) begin
      node = node * 2 + int'(cur_tree[node]);
    end
    victim = WAY_W'(node - WAYS);
  end

  always_comb begin
    int pos;
    int anc;
    int dir;
    nxt_tree = tree_q[t_idx];
    pos = int'(t_way) + WAYS;
    for (int l = 0; l < WAY_W; l++) begin
      anc = pos >> (WAY_W - l);
      dir = (pos >> (WAY_W - l - 1)) & 1;
      nxt_tree[anc] = (dir == 0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch) begin
      tree_q[t_idx] <= nxt_tree;
    end
  end

endmodule

// File: rtl/tgt_predict_buf.sv
module tgt_predict_buf #(
  parameter int PC_W  = 32,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int ALIGN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_target,
  input  logic            up_valid,
  output logic            up_ready,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target
);
  import tpb_pkg::*;

  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = PC_W - IDX_W - ALIGN;

  // lookup side
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  a_valid;
  logic [TAG_W-1:0] a_tag [WAYS];
  logic [PC_W-1:0]  a_tgt [WAYS];
  ctr_t             a_ctr [WAYS];
  logic [WAYS-1:0]  lk_match;
  logic [PC_W-1:0]  lk_sel_tgt;
  ctr_t             lk_sel_ctr;

  // update side
  logic             pend;
  logic [PC_W-1:0]  p_pc;
  logic             p_taken;
  logic [PC_W-1:0]  p_tgt;
  logic [IDX_W-1:0] p_idx;
  logic [TAG_W-1:0] p_tag;
  logic [WAYS-1:0]  b_valid;
  logic [TAG_W-1:0] b_tag [WAYS];
  logic [PC_W-1:0]  b_tgt [WAYS];
  ctr_t             b_ctr [WAYS];
  logic [WAYS-1:0]  up_match;
  logic             up_hit;
  logic [WAY_W-1:0] hit_way;
  logic             inv_any;
  logic [WAY_W-1:0] inv_way;
  logic [WAY_W-1:0] plru_victim;
  logic [WAYS-1:0]  wr_en;
  logic [PC_W-1:0]  wr_tgt;
  ctr_t             wr_ctr;
  logic             touch;
  logic [WAY_W-1:0] touch_way;

  assign lk_idx = lk_pc[ALIGN +: IDX_W];
  assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
  assign p_idx  = p_pc[ALIGN +: IDX_W];
  assign p_tag  = p_pc[PC_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tpb_way #(.SETS(SETS), .TAG_W(TAG_W), .PC_W(PC_W)) u_way (
      .clk      (clk),
      .rst      (rst),
      .ra_idx   (lk_idx),
      .ra_valid (a_valid[w]),
      .ra_tag   (a_tag[w]),
      .ra_tgt   (a_tgt[w]),
      .ra_ctr   (a_ctr[w]),
      .rb_idx   (p_idx),
      .rb_valid (b_valid[w]),
      .rb_tag   (b_tag[w]),
      .rb_tgt   (b_tgt[w]),
      .rb_ctr   (b_ctr[w]),
      .we       (wr_en[w]),
      .w_idx    (p_idx),
      .w_tag    (p_tag),
      .w_tgt    (wr_tgt),
      .w_ctr    (wr_ctr)
    );
    assign lk_match[w] = a_valid[w] && (a_tag[w] == lk_tag);
    assign up_match[w] = b_valid[w] && (b_tag[w] == p_tag);
  end

  tpb_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (p_idx),
    .victim (plru_victim),
    .touch  (touch),
    .t_idx  (p_idx),
    .t_way  (touch_way)
  );

  // at most one way matches, so an OR mux is enough
  always_comb begin
    lk_sel_tgt = '0;
    lk_sel_ctr = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_match[w]) begin
        lk_sel_tgt = lk_sel_tgt | a_tgt[w];
        lk_sel_ctr = lk_sel_ctr | a_ctr[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit    <= 1'b0;
      lk_taken  <= 1'b0;
      lk_target <= '0;
    end else begin
      lk_hit    <= |lk_match;
      lk_taken  <= (|lk_match) && lk_sel_ctr[1];
      lk_target <= ((|lk_match) && lk_sel_ctr[1]) ? lk_sel_tgt : '0;
    end
  end

  // update request capture: one busy cycle per accepted update
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= up_valid && !pend;
  end

  always_ff @(posedge clk) begin
    if (up_valid && !pend) begin
      p_pc    <= up_pc;
      p_taken <= up_taken;
      p_tgt   <= up_target;
    end
  end

  assign up_ready = !pend;

  // matching way and lowest empty way
  always_comb begin
    up_hit  = 1'b0;
    hit_way = '0;
    inv_any = 1'b0;
    inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (up_match[w]) begin
        up_hit  = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!b_valid[w]) begin
        inv_any = 1'b1;
        inv_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    wr_en     = '0;
    wr_tgt    = p_tgt;
    wr_ctr    = CTR_WEAK_TAKEN;
    touch     = 1'b0;
    touch_way = '0;
    if (pend) begin
      if (up_hit) begin
        wr_en[hit_way] = 1'b1;
        wr_ctr         = ctr_step(b_ctr[hit_way], p_taken);
        wr_tgt         = p_taken ? p_tgt : b_tgt[hit_way];
        touch          = 1'b1;
        touch_way      = hit_way;
      end else if (p_taken) begin
        touch_way        = inv_any ? inv_way : plru_victim;
        wr_en[touch_way] = 1'b1;
        touch            = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tpb_checks.sv
module tpb_checks #(
  parameter int PC_W = 32,
  parameter int WAYS = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_hit,
  input logic            lk_taken,
  input logic [PC_W-1:0] lk_target,
  input logic            up_valid,
  input logic            up_ready,
  input logic [WAYS-1:0] lk_match,
  input logic [WAYS-1:0] wr_en
);

  // R1: the first result after reset is a miss
  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!lk_hit && !lk_taken));

  // R5: a redirect needs a hit
  a_r5_taken_needs_hit: assert property (@(posedge clk) disable iff (rst)
    lk_taken |-> lk_hit);

  // R5: no destination is reported without a redirect
  a_r5_target_zero: assert property (@(posedge clk) disable iff (rst)
    !lk_taken |-> (lk_target == '0));

  // R7: an accepted update makes the port busy for the next cycle
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_ready) |=> !up_ready);

  // R7: the busy phase lasts exactly one cycle
  a_r7_busy_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !up_ready |=> up_ready);

  // R9: a branch never occupies two ways of a set
  a_r9_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  // R9: one way written per update at most
  a_r9_single_write: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));

  // R7: writes happen only in the busy cycle
  a_r7_write_when_busy: assert property (@(posedge clk) disable iff (rst)
    (wr_en != '0) |-> !up_ready);

endmodule

bind tgt_predict_buf tpb_checks #(.PC_W(PC_W), .WAYS(WAYS)) u_checks (
  .clk       (clk),
  .rst       (rst),
  .lk_hit    (lk_hit),
  .lk_taken  (lk_taken),
  .lk_target (lk_target),
  .up_valid  (up_valid),
  .up_ready  (up_ready),
  .lk_match  (lk_match),
  .wr_en     (wr_en)
);

// File: tb/tgt_predict_buf_test.sv
module tgt_predict_buf_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_pc = '0;
  logic        lk_hit;
  logic        lk_taken;
  logic [31:0] lk_target;
  logic        up_valid = 1'b0;
  logic        up_ready;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;
  logic [31:0] up_target = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tgt_predict_buf uut (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .lk_target(lk_target), .up_valid(up_valid), .up_ready(up_ready),
    .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target)
  );

  function automatic logic [31:0] mk(input int tag, input int set);
    return {tag[25:0], set[3:0], 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, result registered at the rising edge, sample at the next falling edge
  task automatic look(input logic [31:0] pc, input string req,
                      input bit hit, input bit tk, input logic [31:0] tgt);
    lk_pc = pc;
    @(posedge clk); @(negedge clk);
    chk({req, " hit"}, 32'(lk_hit), 32'(hit));
    chk({req, " taken"}, 32'(lk_taken), 32'(tk));
    chk({req, " target"}, lk_target, tk ? tgt : 32'h0);
  endtask

  task automatic upd(input logic [31:0] pc, input bit tk, input logic [31:0] tgt);
    up_valid = 1'b1; up_pc = pc; up_taken = tk; up_target = tgt;
    @(posedge clk); @(negedge clk);
    up_valid = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ctr;
    logic [31:0] tgt9;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: empty after reset
    chk("R1 ready", 32'(up_ready), 32'd1);
    for (int s = 0; s < 16; s++) look(mk(s + 1, s), "R1 empty", 1'b0, 1'b0, '0);

    // R3: not-taken miss installs nothing
    upd(mk(77, 3), 1'b0, 32'h1234);
    look(mk(77, 3), "R3 no alloc", 1'b0, 1'b0, '0);

    // R4: sweep one taken branch into every set
    for (int s = 0; s < 16; s++) upd(mk(s + 1, s), 1'b1, 32'h4000 + 32'(s) * 32'h100);
    for (int s = 0; s < 16; s++)
      look(mk(s + 1, s), "R4 alloc", 1'b1, 1'b1, 32'h4000 + 32'(s) * 32'h100);

    // R8: low alignment bits ignored, other tag misses
    look(mk(2, 1) | 32'h3, "R8 align bits", 1'b1, 1'b1, 32'h4100);
    look(mk(200, 1), "R8 tag differs", 1'b0, 1'b0, '0);

    // R2: result holds between edges
    look(mk(3, 2), "R2 hit", 1'b1, 1'b1, 32'h4200);
    lk_pc = mk(300, 2);
    #5;
    chk("R2 held", 32'(lk_hit), 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R2 next edge", 32'(lk_hit), 32'd0);

    // R9: fill set 5 (A from sweep, then B, C, D)
    upd(mk(101, 5), 1'b1, 32'hB000);
    upd(mk(102, 5), 1'b1, 32'hC000);
    upd(mk(103, 5), 1'b1, 32'hD000);
    look(mk(6, 5),   "R9 A", 1'b1, 1'b1, 32'h4500);
    look(mk(101, 5), "R9 B", 1'b1, 1'b1, 32'hB000);
    look(mk(102, 5), "R9 C", 1'b1, 1'b1, 32'hC000);
    look(mk(103, 5), "R9 D", 1'b1, 1'b1, 32'hD000);

    // R10: touch A, install E; tree points at C (way 2)
    upd(mk(6, 5), 1'b1, 32'h4500);
    upd(mk(104, 5), 1'b1, 32'hE000);
    look(mk(6, 5),   "R10 A kept", 1'b1, 1'b1, 32'h4500);
    look(mk(101, 5), "R10 B kept", 1'b1, 1'b1, 32'hB000);
    look(mk(102, 5), "R10 C evicted", 1'b0, 1'b0, '0);
    look(mk(103, 5), "R10 D kept", 1'b1, 1'b1, 32'hD000);
    look(mk(104, 5), "R10 E in", 1'b1, 1'b1, 32'hE000);

    // R5: counter walk on set 9 entry, starting at weakly taken
    ctr = 2;
    tgt9 = 32'h4900;
    for (int i = 0; i < 10; i++) begin
      bit t;
      t = (i >= 3 && i <= 6);  // N N N T T T T N N N
      upd(mk(10, 9), t, tgt9);
      ctr = t ? ((ctr == 3) ? 3 : ctr + 1) : ((ctr == 0) ? 0 : ctr - 1);
      look(mk(10, 9), "R5 counter", 1'b1, ctr >= 2, tgt9);
    end

    // R6: counter now 0; raise to 3 with a new destination
    upd(mk(10, 9), 1'b1, 32'h9990);
    upd(mk(10, 9), 1'b1, 32'h9990);
    upd(mk(10, 9), 1'b1, 32'h9990);
    look(mk(10, 9), "R6 overwrite", 1'b1, 1'b1, 32'h9990);
    upd(mk(10, 9), 1'b0, 32'h5550);
    look(mk(10, 9), "R6 not-taken keeps", 1'b1, 1'b1, 32'h9990);

    // R7: busy cycle, second offer ignored
    up_valid = 1'b1; up_pc = mk(50, 12); up_taken = 1'b1; up_target = 32'hAAA0;
    @(posedge clk); @(negedge clk);
    chk("R7 busy", 32'(up_ready), 32'd0);
    up_pc = mk(51, 12); up_target = 32'hBBB0;
    @(posedge clk); @(negedge clk);
    up_valid = 1'b0;
    chk("R7 ready again", 32'(up_ready), 32'd1);
    look(mk(50, 12), "R7 first taken", 1'b1, 1'b1, 32'hAAA0);
    look(mk(51, 12), "R7 ignored", 1'b0, 1'b0, '0);

    // R11: lookup at the write edge sees old contents
    up_valid = 1'b1; up_pc = mk(60, 14); up_taken = 1'b1; up_target = 32'hCCC0;
    @(posedge clk); @(negedge clk);
    up_valid = 1'b0;
    lk_pc = mk(60, 14);
    @(posedge clk); @(negedge clk);
    chk("R11 old view", 32'(lk_hit), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R11 new view", 32'(lk_hit), 32'd1);
    chk("R11 new target", lk_target, 32'hCCC0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule